// File: doc/BRIEF.md
# Fault Interrupt Status Controller

This block collects fault events from a multi-channel input front end and turns them into latched status, masked interrupt requests and one interrupt line to a host. It has three event sources. The first is a clock-error event. The second is a supply-short event. The third is a vector of input faults: six channels with eight fault types per channel. Every event is latched whether or not it is masked. The mask settings only decide whether a newly latched event raises the interrupt line.

The host reaches the block through a small register port. The port has a write strobe, a read strobe, a 5-bit address and 8-bit data. Read data comes back on the cycle after the read strobe. Reading a latched register clears it, and the read returns the value the register held before the clear. The interrupt line has a programmable polarity. It can run in one of three forms: a single pulse of programmable length, a repeating pulse train, or a level that is held until the host reads a latched status register.

Top module: `fault_irq_ctrl`

## Requirements
- R1: The clock-error event sets bit 0 of the misc latched register (address 0x09). It raises an interrupt only while bit 0 of the misc mask register (address 0x02) is 0. Bit 0 of the live register (address 0x08) follows the clock-error input directly and is never latched.
- R2: The supply-short event works the same way through bit 1 of each of those three registers.
- R3: Channel c takes its events on ch_fault_i[8c+7:8c] and latches them in the byte at address 0x10+c. The bit positions are: 7 open input, 6 inputs shorted together, 5 P-input to ground, 4 M-input to ground, 3 P-input to bias, 2 M-input to bias, 1 P-input to supply, 0 M-input to supply.
- R4: A channel fault of type t on channel c raises an interrupt only when bit c of the channel mask (0x03) and bit t of the type mask (0x04) are both 0. The fault is latched regardless of either mask.
- R5: Bit c of the summary register (0x0A) is 1 exactly when channel c has any latched bit set.
- R6: A read of any channel latch address clears the latches of all channels, which also clears the summary. A read of 0x09 clears only the misc latches. Reading the summary or the live register clears nothing.
- R7: An event that arrives in the same cycle as a read that clears its latch stays latched.
- R8: Bit 7 of the configuration register (0x00) selects the line polarity: 1 means active high and 0 means active low.
- R9: When configuration bits 6:5 are 00 (single pulse), each new unmasked fault holds the line active for P cycles. P is the value of the length register (0x01), and a value of 0 acts as 1. The pulse starts at the clock edge that latches the fault. An event whose latch bit is already set does not start a new pulse.
- R10: When bits 6:5 are 01 (pulse train), a new unmasked fault starts a train that is active for 16 cycles and idle for 16 cycles, repeating. The train stops at the first read of 0x09 or of a channel latch.
- R11: When bits 6:5 are 1x (level), a new unmasked fault holds the line active until the first read of 0x09 or of a channel latch.
- R12: After reset, the configuration register is 0x00, the length register is 16, the misc mask is 0x03, the channel mask is 0x3F, the type mask is 0xFF, all latches are 0 and irq_o is 1.
- R13: rd_data_o holds the addressed register's value from the clock edge that samples rd_en_i, captured before any clear caused by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_err_i | input | 1 | Clock-error event |
| sup_short_i | input | 1 | Supply-short event |
| ch_fault_i | input | 48 | Per-channel fault events, 8 bits per channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request line |

## Verification
The hardest case to produce from the ports is a fault that arrives in exactly the cycle in which a clearing read lands. To create it, the bench first latches a different bit in the same channel. It then raises the new event and the read strobe of another channel's latch on the same falling edge. Afterwards it reads the channel back and expects the old bit to be gone and the new bit to remain. The two-level mask is swept over every channel and every fault type. Each pair is tried in three settings: fully unmasked, blocked by the channel mask, and blocked by the type mask. In every setting the bench measures the pulse length and reads back the latched byte and the summary.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_CFG   = 5'h00;
  localparam logic [AW-1:0] A_PLEN  = 5'h01;
  localparam logic [AW-1:0] A_MMASK = 5'h02;
  localparam logic [AW-1:0] A_CMASK = 5'h03;
  localparam logic [AW-1:0] A_TMASK = 5'h04;
  localparam logic [AW-1:0] A_LIVE  = 5'h08;
  localparam logic [AW-1:0] A_MLAT  = 5'h09;
  localparam logic [AW-1:0] A_SUMM  = 5'h0A;
  localparam logic [AW-1:0] A_CH0   = 5'h10;

  typedef enum logic [1:0] {
    EV_SINGLE = 2'b00,
    EV_TRAIN  = 2'b01,
    EV_LEVEL  = 2'b10,
    EV_LEVEL2 = 2'b11
  } ev_mode_e;
endpackage

// File: rtl/fic_regs.sv
module fic_regs
  import fic_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int PULSE_DEF = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [1:0]           live,
  input  logic [1:0]           misc_lat,
  input  logic [NUM_CH-1:0]    summary,
  input  logic [NUM_CH*8-1:0]  ch_lat,
  output logic                 pol,
  output ev_mode_e             mode,
  output logic [DW-1:0]        plen,
  output logic [1:0]           misc_mask,
  output logic [NUM_CH-1:0]    ch_mask,
  output logic [7:0]           type_mask,
  output logic [DW-1:0]        rd_data
);
  logic [2:0]        cfg_q;
  logic [DW-1:0]     plen_q;
  logic [1:0]        mmask_q;
  logic [NUM_CH-1:0] cmask_q;
  logic [7:0]        tmask_q;
  logic [DW-1:0]     rd_q, rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CFG:   rd_mux = {cfg_q, 5'b0};
      A_PLEN:  rd_mux = plen_q;
      A_MMASK: rd_mux = DW'(mmask_q);
      A_CMASK: rd_mux = DW'(cmask_q);
      A_TMASK: rd_mux = tmask_q;
      A_LIVE:  rd_mux = DW'(live);
      A_MLAT:  rd_mux = DW'(misc_lat);
      A_SUMM:  rd_mux = DW'(summary);
      default: rd_mux = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == A_CH0 + AW'(c)) rd_mux = ch_lat[c*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      plen_q  <= DW'(PULSE_DEF);
      mmask_q <= '1;
      cmask_q <= '1;
      tmask_q <= '1;
      rd_q    <= '0;
    end else begin
      if (wr_en && addr == A_CFG)   cfg_q   <= wr_data[7:5];
      if (wr_en && addr == A_PLEN)  plen_q  <= wr_data;
      if (wr_en && addr == A_MMASK) mmask_q <= wr_data[1:0];
      if (wr_en && addr == A_CMASK) cmask_q <= wr_data[NUM_CH-1:0];
      if (wr_en && addr == A_TMASK) tmask_q <= wr_data;
      if (rd_en)                    rd_q    <= rd_mux;
    end
  end

  assign pol       = cfg_q[2];
  assign mode      = ev_mode_e'(cfg_q[1:0]);
  assign plen      = plen_q;
  assign misc_mask = mmask_q;
  assign ch_mask   = cmask_q;
  assign type_mask = tmask_q;
  assign rd_data   = rd_q;

  // R4
  cmask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMASK) |=> (ch_mask == $past(wr_data[NUM_CH-1:0])));
endmodule

// File: rtl/fic_latch.sv
module fic_latch #(
  parameter int NUM_CH    = 6,
  parameter int NUM_TYPES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH*NUM_TYPES-1:0] ch_ev,
  input  logic [1:0]                  misc_ev,
  input  logic                        ch_clr,
  input  logic                        misc_clr,
  input  logic [NUM_CH-1:0]           ch_mask,
  input  logic [NUM_TYPES-1:0]        type_mask,
  input  logic [1:0]                  misc_mask,
  output logic [NUM_CH*NUM_TYPES-1:0] ch_lat,
  output logic [1:0]                  misc_lat,
  output logic [NUM_CH-1:0]           summary,
  output logic                        trig
);
  localparam int NB = NUM_CH * NUM_TYPES;

  logic [NB-1:0]     ch_lat_q, ch_lat_d;
  logic [1:0]        misc_lat_q, misc_lat_d;
  logic [NUM_CH-1:0] ch_hit;
  logic              misc_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_TYPES-1:0] cur, ev, fresh;
    assign cur   = ch_lat_q[c*NUM_TYPES +: NUM_TYPES];
    assign ev    = ch_ev[c*NUM_TYPES +: NUM_TYPES];
    assign fresh = ev & ~cur & ~type_mask & {NUM_TYPES{~ch_mask[c]}};
    assign ch_lat_d[c*NUM_TYPES +: NUM_TYPES] = (cur & {NUM_TYPES{~ch_clr}}) | ev;
    assign ch_hit[c]  = |fresh;
    assign summary[c] = |cur;
  end

  assign misc_lat_d = (misc_lat_q & {2{~misc_clr}}) | misc_ev;
  assign misc_hit   = |(misc_ev & ~misc_lat_q & ~misc_mask);
  assign trig       = misc_hit | (|ch_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_lat_q   <= '0;
      misc_lat_q <= '0;
    end else begin
      ch_lat_q   <= ch_lat_d;
      misc_lat_q <= misc_lat_d;
    end
  end

  assign ch_lat   = ch_lat_q;
  assign misc_lat = misc_lat_q;

  // R6
  ch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_clr |=> ((ch_lat_q & $past(ch_lat_q)) == $past(ch_lat_q)));
  // R6
  ch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_clr && ch_ev == '0) |=> (ch_lat_q == '0));
  // R7
  ev_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ev != '0) |=> ((ch_lat_q & $past(ch_ev)) == $past(ch_ev)));
  // R1
  misc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misc_ev != '0) |=> ((misc_lat_q & $past(misc_ev)) == $past(misc_ev)));
endmodule

// File: rtl/fic_irq_gen.sv
module fic_irq_gen
  import fic_pkg::*;
#(
  parameter int TRAIN_PERIOD = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          clr_rd,
  input  ev_mode_e      mode,
  input  logic [DW-1:0] plen,
  output logic          act
);
  localparam int PH_W = $clog2(TRAIN_PERIOD);
  localparam logic [PH_W-1:0] HALF = PH_W'(TRAIN_PERIOD / 2);

  logic [DW-1:0]   pcnt_q, pcnt_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            run_q, run_d;

  always_comb begin
    pcnt_d  = pcnt_q;
    phase_d = phase_q;
    run_d   = run_q;
    if (trig) begin
      pcnt_d  = (plen == '0) ? DW'(1) : plen;
      phase_d = '0;
      run_d   = 1'b1;
    end else begin
      if (pcnt_q != '0) pcnt_d = pcnt_q - 1'b1;
      if (run_q)        phase_d = phase_q + 1'b1;
      if (clr_rd)       run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      pcnt_q  <= pcnt_d;
      phase_q <= phase_d;
      run_q   <= run_d;
    end
  end

  always_comb begin
    case (mode)
      EV_SINGLE: act = (pcnt_q != '0);
      EV_TRAIN:  act = run_q && (phase_q < HALF);
      default:   act = run_q;
    endcase
  end

  // R9
  trig_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> act);
  // R9
  pulse_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && pcnt_q != '0) |=> (pcnt_q == $past(pcnt_q) - 1'b1));
  // R10
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !trig) |=> !run_q);
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fic_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter int NUM_TYPES    = 8,
  parameter int PULSE_DEF    = 16,
  parameter int TRAIN_PERIOD = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clk_err_i,
  input  logic                        sup_short_i,
  input  logic [NUM_CH*NUM_TYPES-1:0] ch_fault_i,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wr_data_i,
  output logic [DW-1:0]               rd_data_o,
  output logic                        irq_o
);
  logic [1:0]                  misc_ev, misc_lat, misc_mask;
  logic [NUM_CH*NUM_TYPES-1:0] ch_lat;
  logic [NUM_CH-1:0]           summary, ch_mask;
  logic [NUM_TYPES-1:0]        type_mask;
  logic [DW-1:0]               plen;
  ev_mode_e                    mode;
  logic                        pol, ch_clr, misc_clr, trig, act;

  assign misc_ev = {sup_short_i, clk_err_i};

  always_comb begin
    ch_clr = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_en_i && addr_i == A_CH0 + AW'(c)) ch_clr = 1'b1;
    end
  end
  assign misc_clr = rd_en_i && (addr_i == A_MLAT);

  fic_regs #(.NUM_CH(NUM_CH), .PULSE_DEF(PULSE_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .rd_en(rd_en_i),
    .addr(addr_i), .wr_data(wr_data_i), .live(misc_ev),
    .misc_lat(misc_lat), .summary(summary), .ch_lat(ch_lat),
    .pol(pol), .mode(mode), .plen(plen), .misc_mask(misc_mask),
    .ch_mask(ch_mask), .type_mask(type_mask), .rd_data(rd_data_o)
  );

  fic_latch #(.NUM_CH(NUM_CH), .NUM_TYPES(NUM_TYPES)) u_latch (
    .clk(clk), .rst_n(rst_n), .ch_ev(ch_fault_i), .misc_ev(misc_ev),
    .ch_clr(ch_clr), .misc_clr(misc_clr), .ch_mask(ch_mask),
    .type_mask(type_mask), .misc_mask(misc_mask), .ch_lat(ch_lat),
    .misc_lat(misc_lat), .summary(summary), .trig(trig)
  );

  fic_irq_gen #(.TRAIN_PERIOD(TRAIN_PERIOD)) u_irq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .clr_rd(ch_clr | misc_clr),
    .mode(mode), .plen(plen), .act(act)
  );

  assign irq_o = pol ? act : ~act;
endmodule

// File: tb/test_fault_irq_ctrl.sv
module test_fault_irq_ctrl;
  import fic_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_err = 1'b0, sup_short = 1'b0;
  logic [47:0] ch_fault = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic        irq;
  logic        act_lvl = 1'b0;
  int          checks = 0, fails = 0;

  always #4 clk = ~clk;

  fault_irq_ctrl i_fault_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_err_i(clk_err), .sup_short_i(sup_short),
    .ch_fault_i(ch_fault), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic count_act(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      if (irq == act_lvl) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_ch(input int c, input int t);
    ch_fault[c*8+t] = 1'b1;
    @(negedge clk);
    ch_fault = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq idle", int'(irq), 1);
    rd(A_CFG, d);   chk("R12 cfg", d, 0);
    rd(A_PLEN, d);  chk("R12 plen", d, 16);
    rd(A_MMASK, d); chk("R12 misc mask", d, 3);
    rd(A_CMASK, d); chk("R12 ch mask", d, 8'h3F);
    rd(A_TMASK, d); chk("R12 type mask", d, 8'hFF);
    rd(A_SUMM, d);  chk("R12 summary", d, 0);
    rd(A_MLAT, d);  chk("R12 misc latch", d, 0);

    // R3 R4 R5 R6 R9 sweep over all channel/type pairs and three mask settings
    for (int c = 0; c < 6; c++) begin
      for (int t = 0; t < 8; t++) begin
        for (int k = 0; k < 3; k++) begin
          wr(A_CMASK, (k == 1) ? 8'h3F : (8'h3F & ~(8'(1) << c)));
          wr(A_TMASK, (k == 2) ? 8'hFF : ~(8'(1) << t));
          pulse_ch(c, t);
          count_act(40, n);
          chk("R4 two-level mask pulse", n, (k == 0) ? 16 : 0);
          rd(A_SUMM, d);
          chk("R5 summary bit", d, 1 << c);
          rd(A_CH0 + 5'(c), d);
          chk("R3 latched byte", d, 1 << t);
          rd(A_SUMM, d);
          chk("R6 summary cleared", d, 0);
        end
      end
    end

    // R6 one channel read clears all channels
    pulse_ch(1, 0); pulse_ch(4, 7);
    rd(A_CH0 + 5'd5, d);
    chk("R6 read ch5 empty", d, 0);
    rd(A_CH0 + 5'd1, d); chk("R6 ch1 cleared", d, 0);
    rd(A_CH0 + 5'd4, d); chk("R6 ch4 cleared", d, 0);

    // R9 no retrigger on already latched bit
    wr(A_CMASK, 8'h00); wr(A_TMASK, 8'h00);
    pulse_ch(2, 3); count_act(40, n); chk("R9 first pulse", n, 16);
    pulse_ch(2, 3); count_act(40, n); chk("R9 no retrigger", n, 0);
    rd(A_CH0 + 5'd2, d);

    // R9 programmable length, zero acts as one
    wr(A_PLEN, 8'd5);
    pulse_ch(0, 6); count_act(40, n); chk("R9 length 5", n, 5);
    rd(A_CH0, d);
    wr(A_PLEN, 8'd0);
    pulse_ch(0, 6); count_act(40, n); chk("R9 length 0 as 1", n, 1);
    rd(A_CH0, d);
    wr(A_PLEN, 8'd16);

    // R7 R13 event in same cycle as clearing read
    pulse_ch(3, 7);
    addr = A_CH0; rd_en = 1'b1; ch_fault[3*8+1] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; ch_fault = '0;
    chk("R13 pre-clear read data", rd_data, 0);
    rd(A_CH0 + 5'd3, d);
    chk("R7 event kept, old bit cleared", d, 8'h02);
    @(negedge clk);

    // R1 clock error
    wr(A_MMASK, 8'h02);
    clk_err = 1'b1; @(negedge clk);
    count_act(40, n); chk("R1 unmasked pulse", n, 16);
    rd(A_LIVE, d); chk("R1 live set", d, 1);
    clk_err = 1'b0; @(negedge clk);
    rd(A_LIVE, d); chk("R1 live clear", d, 0);
    rd(A_MLAT, d); chk("R1 R13 latched", d, 1);
    rd(A_MLAT, d); chk("R6 misc cleared on read", d, 0);
    wr(A_MMASK, 8'h03);
    clk_err = 1'b1; @(negedge clk); clk_err = 1'b0;
    count_act(40, n); chk("R1 masked no pulse", n, 0);
    rd(A_MLAT, d); chk("R1 masked still latched", d, 1);

    // R2 supply short
    wr(A_MMASK, 8'h01);
    sup_short = 1'b1; @(negedge clk); sup_short = 1'b0;
    count_act(40, n); chk("R2 unmasked pulse", n, 16);
    rd(A_MLAT, d); chk("R2 latched", d, 2);
    wr(A_MMASK, 8'h03);
    sup_short = 1'b1; @(negedge clk); sup_short = 1'b0;
    count_act(40, n); chk("R2 masked no pulse", n, 0);
    rd(A_MLAT, d);

    // R8 polarity active high
    wr(A_CFG, 8'h80); act_lvl = 1'b1;
    chk("R8 idle low", int'(irq), 0);
    pulse_ch(5, 2); count_act(40, n); chk("R8 high pulse", n, 16);
    rd(A_CH0 + 5'd5, d);

    // R10 pulse train
    wr(A_CFG, 8'hA0);
    pulse_ch(0, 0);
    count_act(16, n); chk("R10 first high half", n, 16);
    count_act(16, n); chk("R10 first low half", n, 0);
    count_act(96, n); chk("R10 repeats", n, 48);
    rd(A_CH0, d);
    count_act(64, n); chk("R10 stopped by read", n, 0);

    // R11 level mode
    wr(A_CFG, 8'hC0);
    pulse_ch(1, 1);
    count_act(50, n); chk("R11 held", n, 50);
    rd(A_CH0 + 5'd1, d); chk("R11 latched byte", d, 8'h02);
    count_act(20, n); chk("R11 released", n, 0);
    wr(A_MMASK, 8'h02);
    clk_err = 1'b1; @(negedge clk); clk_err = 1'b0;
    count_act(10, n); chk("R11 misc held", n, 10);
    rd(A_MLAT, d);
    count_act(10, n); chk("R11 misc release", n, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule